// File: doc/BRIEF.md
# Fractional clock divider generator

This block produces one output clock from a single, already selected input clock. The division ratio is a fixed-point number made of a 16-bit whole part and a 16-bit fraction. Fractions are realised by dithering: some periods are one input cycle longer than others, so that over many periods the average length equals the programmed ratio. Either part of the ratio may be rewritten while the output runs. A new value takes effect at the next period boundary.

The output is started and stopped through an enable bit without runt pulses. A kill bit stops it at once, without waiting for a clock edge. Further controls are:

- duty-cycle correction, which makes odd-length periods high for exactly half their length;
- a start delay of zero to three input cycles, applied when the generator is enabled;
- a nudge bit, each edge of which shifts the running output one input cycle later.

A status output tells software whether the generator is actually producing a clock. All control inputs are assumed to come from a register block in the input-clock domain.

Top module: `frac_clk_div`

## Requirements
- R1: For whole part N (2 or more) and fraction 0, each output period lasts N input cycles. The output is high for the first floor(N/2) cycles of the period and low for the rest.
- R2: A whole part of 0 is taken as 65536. The output then stays high for 32768 input cycles per period.
- R3: A whole part of 1 is raised to 2, giving one high and one low input cycle per period.
- R4: A 16-bit accumulator adds the fraction once per period. A period in which the addition carries out is one input cycle longer, so the average period is N + F/65536. The accumulator is cleared by reset and by kill. The first period after a start therefore carries only if the fraction itself overflows.
- R5: With duty correction on, a period of odd length L stays high for L/2 input cycles, that is, floor(L/2) cycles plus one half cycle. Even lengths are unchanged.
- R6: Changes to the whole part, the fraction and the duty-correction bit are applied only when a new period begins. The period in progress keeps its length and its high time.
- R7: Count input rising edges from the first one that samples enable high. The output first rises on edge number 3 + PH, where PH is the 2-bit start-delay field.
- R8: The start-delay field is read only when an idle generator accepts enable. Writing it while the output runs changes neither the period nor the timing of the running output.
- R9: After enable is cleared, the period in progress completes with its full high time. The output then stays low. The status output falls on the edge that ends that period.
- R10: While kill is high, the output and the status are low. They go low as soon as kill rises, with no input clock edge needed, and stay low after kill is released until enable is set again.
- R11: Each edge of the nudge bit, rising or falling, seen while the output runs, lengthens one upcoming period by one input cycle. The extra cycle is added to its low phase. Nudge edges seen while the generator is idle or waiting out the start delay are discarded.
- R12: After reset, the output and the status are low. The status rises on the same input edge as the first output rising edge after a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Selected input clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctl_enable | input | 1 | Start (1) or cleanly stop (0) the generator |
| ctl_kill | input | 1 | Asynchronous stop; release only while ctl_enable is low |
| ctl_dc50 | input | 1 | Duty correction for odd period lengths |
| ctl_phase | input | 2 | Start delay in input cycles |
| ctl_nudge | input | 1 | Each edge delays the running output by one input cycle |
| div_int | input | 16 | Whole part of the divisor (0 means 65536) |
| div_frac | input | 16 | Fractional part of the divisor, in units of 1/65536 |
| clk_out | output | 1 | Divided output clock |
| enabled | output | 1 | High while the generator is producing periods |

## Verification
The properties assume that every control input except kill changes only between input edges, synchronously to the input clock. They also assume that kill is released only while enable is already low. The bench drives all controls just after a falling edge. It asserts kill either together with clearing enable or part-way through a cycle, and releases kill one cycle after enable has been low. Nudge edges are applied only after the output has been seen to rise, so that each edge is detected well before the end of the period it is meant to stretch.

// File: rtl/fdiv_pkg.sv
// Shared declarations for the fractional clock divider.
// Assumes nothing beyond IEEE 1800-2017 packages.
package fdiv_pkg;

    // Generator sequencing state: waiting for enable, counting the start
    // delay, or producing output periods.
    typedef enum logic [1:0] {
        GEN_IDLE  = 2'd0,
        GEN_DELAY = 2'd1,
        GEN_RUN   = 2'd2
    } gen_state_t;

endpackage

// File: rtl/fdiv_period_calc.sv
// Computes the length, the high time and the half-cycle extension flag of
// the next output period from the divisor fields. It also owns the
// fractional accumulator, which advances once per loaded period.
// Assumes: divisor and duty bit are synchronous to clk_in; ctl_kill is
// asynchronous and clears the accumulator.
module fdiv_period_calc #(
    parameter int INT_W  = 16,
    parameter int FRAC_W = 16
) (
    input  logic                clk_in,
    input  logic                rst_n,
    input  logic                ctl_kill,
    input  logic                load,
    input  logic [INT_W-1:0]    div_int,
    input  logic [FRAC_W-1:0]   div_frac,
    input  logic                ctl_dc50,
    output logic [INT_W:0]      p_nx,
    output logic [INT_W:0]      h_nx,
    output logic                ext_nx
);
    localparam int CNT_W = INT_W + 1;

    logic [FRAC_W-1:0] acc;
    logic [FRAC_W:0]   sum;
    logic [CNT_W-1:0]  base;

    // Next-period arithmetic: fraction carry, whole-part mapping, high time.
    always_comb begin
        sum = {1'b0, acc} + {1'b0, div_frac};
        if (div_int == '0) begin
            base = CNT_W'(1) << INT_W;
        end else if (div_int == INT_W'(1)) begin
            base = CNT_W'(2);
        end else begin
            base = CNT_W'(div_int);
        end
        p_nx   = base + CNT_W'(sum[FRAC_W]);
        h_nx   = p_nx >> 1;
        ext_nx = ctl_dc50 & p_nx[0];
    end

    // Fractional accumulator: steps once per loaded period, cleared by kill.
    always_ff @(posedge clk_in or posedge ctl_kill) begin
        if (ctl_kill) begin
            acc <= '0;
        end else if (!rst_n) begin
            acc <= '0;
        end else if (load) begin
            acc <= sum[FRAC_W-1:0];
        end
    end

    // R3 and R5: any loaded period has a high phase and a low phase.
    a_r3_period_floor: assert property (@(posedge clk_in) disable iff (!rst_n || ctl_kill)
        load |-> (p_nx >= CNT_W'(2)) && (h_nx >= CNT_W'(1)) && (h_nx < p_nx));

endmodule

// File: rtl/fdiv_start_ctl.sv
// Sequences the generator: samples enable, applies the start delay taken
// from the phase field when leaving idle, runs, and stops only at a period
// boundary. It drives the status flag.
// Assumes: ctl_enable and ctl_phase are synchronous to clk_in; ctl_kill is
// asynchronous and released only while ctl_enable is low.
module fdiv_start_ctl
    import fdiv_pkg::*;
#(
    parameter int PH_W = 2
) (
    input  logic             clk_in,
    input  logic             rst_n,
    input  logic             ctl_kill,
    input  logic             ctl_enable,
    input  logic [PH_W-1:0]  ctl_phase,
    input  logic             at_end,
    output logic             start,
    output logic             cont,
    output logic             running,
    output logic             enabled
);
    gen_state_t       state;
    logic             en_q;
    logic [PH_W-1:0]  dly;

    // Decode start, continue and run conditions from the state.
    always_comb begin
        start   = (state == GEN_DELAY) && en_q && (dly == '0);
        cont    = (state == GEN_RUN) && at_end && en_q;
        running = (state == GEN_RUN);
    end

    // Sequencer: idle, start delay, run; kill forces idle at once.
    always_ff @(posedge clk_in or posedge ctl_kill) begin
        if (ctl_kill) begin
            state   <= GEN_IDLE;
            en_q    <= 1'b0;
            dly     <= '0;
            enabled <= 1'b0;
        end else if (!rst_n) begin
            state   <= GEN_IDLE;
            en_q    <= 1'b0;
            dly     <= '0;
            enabled <= 1'b0;
        end else begin
            en_q <= ctl_enable;
            case (state)
                GEN_IDLE: begin
                    if (en_q) begin
                        state <= GEN_DELAY;
                        dly   <= ctl_phase;
                    end
                end
                GEN_DELAY: begin
                    if (!en_q) begin
                        state <= GEN_IDLE;
                    end else if (dly == '0) begin
                        state   <= GEN_RUN;
                        enabled <= 1'b1;
                    end else begin
                        dly <= dly - PH_W'(1);
                    end
                end
                GEN_RUN: begin
                    if (at_end && !en_q) begin
                        state   <= GEN_IDLE;
                        enabled <= 1'b0;
                    end
                end
                default: state <= GEN_IDLE;
            endcase
        end
    end

    // R7: the start delay falls by exactly one per input cycle.
    a_r7_delay_counts_down: assert property (@(posedge clk_in) disable iff (!rst_n || ctl_kill)
        (state == GEN_DELAY && en_q && dly != '0) |=>
            (state == GEN_DELAY && dly == $past(dly) - PH_W'(1)));

endmodule

// File: rtl/fdiv_wave_gen.sv
// Counts input cycles within the current period and forms the output
// waveform. It holds the period parameters loaded at each boundary, adds
// pending nudge cycles to the low phase, and extends the high phase by a
// half cycle through a falling-edge register when the period is odd and
// duty correction is on.
// Assumes: the period parameters satisfy 1 <= high < length; ctl_nudge is
// synchronous to clk_in; ctl_kill is asynchronous.
module fdiv_wave_gen #(
    parameter int CNT_W   = 17,
    parameter int NUDGE_W = 3
) (
    input  logic              clk_in,
    input  logic              rst_n,
    input  logic              ctl_kill,
    input  logic              load,
    input  logic              running,
    input  logic              ctl_nudge,
    input  logic [CNT_W-1:0]  p_nx,
    input  logic [CNT_W-1:0]  h_nx,
    input  logic              ext_nx,
    output logic              at_end,
    output logic              clk_out
);
    logic [CNT_W-1:0]   cnt;
    logic [CNT_W-1:0]   cnt_inc;
    logic [CNT_W-1:0]   p_cur;
    logic [CNT_W-1:0]   h_cur;
    logic               ext_cur;
    logic               hi_pos;
    logic               hi_neg;
    logic               nud_q;
    logic               nud_qq;
    logic               nud_edge;
    logic [NUDGE_W-1:0] pend;
    logic               last_cnt;
    logic               stretch;
    logic               pend_inc;

    // Period-position decode and nudge edge detection.
    always_comb begin
        cnt_inc  = cnt + CNT_W'(1);
        last_cnt = (cnt == p_cur - CNT_W'(1));
        at_end   = running && last_cnt && (pend == '0);
        stretch  = running && last_cnt && (pend != '0);
        nud_edge = nud_q ^ nud_qq;
        pend_inc = nud_edge && (pend != '1);
        clk_out  = hi_pos | hi_neg;
    end

    // Period parameter holding registers, updated only at a boundary.
    always_ff @(posedge clk_in) begin
        if (!rst_n) begin
            p_cur   <= CNT_W'(2);
            h_cur   <= CNT_W'(1);
            ext_cur <= 1'b0;
        end else if (load) begin
            p_cur   <= p_nx;
            h_cur   <= h_nx;
            ext_cur <= ext_nx;
        end
    end

    // Cycle counter and rising-edge-timed output level.
    always_ff @(posedge clk_in or posedge ctl_kill) begin
        if (ctl_kill) begin
            cnt    <= '0;
            hi_pos <= 1'b0;
        end else if (!rst_n) begin
            cnt    <= '0;
            hi_pos <= 1'b0;
        end else if (load) begin
            cnt    <= '0;
            hi_pos <= 1'b1;
        end else if (running && !last_cnt) begin
            cnt    <= cnt_inc;
            hi_pos <= (cnt_inc < h_cur);
        end else if (stretch) begin
            hi_pos <= 1'b0;
        end else begin
            cnt    <= '0;
            hi_pos <= 1'b0;
        end
    end

    // Nudge synchroniser and pending-cycle count, emptied whenever not running.
    always_ff @(posedge clk_in or posedge ctl_kill) begin
        if (ctl_kill) begin
            nud_q  <= 1'b0;
            nud_qq <= 1'b0;
            pend   <= '0;
        end else if (!rst_n) begin
            nud_q  <= 1'b0;
            nud_qq <= 1'b0;
            pend   <= '0;
        end else begin
            nud_q  <= ctl_nudge;
            nud_qq <= nud_q;
            if (!running) begin
                pend <= '0;
            end else if (pend_inc && !stretch) begin
                pend <= pend + NUDGE_W'(1);
            end else if (stretch && !pend_inc) begin
                pend <= pend - NUDGE_W'(1);
            end
        end
    end

    // Half-cycle extension register for odd periods with duty correction.
    always_ff @(negedge clk_in or posedge ctl_kill) begin
        if (ctl_kill) begin
            hi_neg <= 1'b0;
        end else if (!rst_n) begin
            hi_neg <= 1'b0;
        end else begin
            hi_neg <= hi_pos & ext_cur;
        end
    end

    // R1: the count never leaves the current period.
    a_r1_cnt_in_period: assert property (@(posedge clk_in) disable iff (!rst_n || ctl_kill)
        running |-> (cnt < p_cur));

    // R6: period parameters stay put unless a new period is loaded.
    a_r6_divisor_held: assert property (@(posedge clk_in) disable iff (!rst_n || ctl_kill)
        (running && !load) |=> $stable(p_cur) && $stable(h_cur) && $stable(ext_cur));

    // R11: a pending nudge holds the last count one extra low cycle.
    a_r11_nudge_stretch: assert property (@(posedge clk_in) disable iff (!rst_n || ctl_kill)
        (running && last_cnt && pend != '0) |=> (cnt == $past(cnt)) && !hi_pos);

endmodule

// File: rtl/frac_clk_div.sv
// Top level of the fractional clock divider. It connects the sequencer,
// the period calculator and the waveform generator.
// Assumes: clk_in is the single, already selected source; every control
// except ctl_kill is synchronous to clk_in; ctl_kill is released only
// while ctl_enable is low.
module frac_clk_div #(
    parameter int INT_W   = 16,
    parameter int FRAC_W  = 16,
    parameter int PH_W    = 2,
    parameter int NUDGE_W = 3
) (
    input  logic               clk_in,
    input  logic               rst_n,
    input  logic               ctl_enable,
    input  logic               ctl_kill,
    input  logic               ctl_dc50,
    input  logic [PH_W-1:0]    ctl_phase,
    input  logic               ctl_nudge,
    input  logic [INT_W-1:0]   div_int,
    input  logic [FRAC_W-1:0]  div_frac,
    output logic               clk_out,
    output logic               enabled
);
    localparam int CNT_W = INT_W + 1;

    logic             start;
    logic             cont;
    logic             running;
    logic             at_end;
    logic             load;
    logic [CNT_W-1:0] p_nx;
    logic [CNT_W-1:0] h_nx;
    logic             ext_nx;

    // A new period is loaded on a start or on an uninterrupted boundary.
    always_comb load = start | cont;

    fdiv_start_ctl #(.PH_W(PH_W)) u_seq (
        .clk_in     (clk_in),
        .rst_n      (rst_n),
        .ctl_kill   (ctl_kill),
        .ctl_enable (ctl_enable),
        .ctl_phase  (ctl_phase),
        .at_end     (at_end),
        .start      (start),
        .cont       (cont),
        .running    (running),
        .enabled    (enabled)
    );

    fdiv_period_calc #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_calc (
        .clk_in   (clk_in),
        .rst_n    (rst_n),
        .ctl_kill (ctl_kill),
        .load     (load),
        .div_int  (div_int),
        .div_frac (div_frac),
        .ctl_dc50 (ctl_dc50),
        .p_nx     (p_nx),
        .h_nx     (h_nx),
        .ext_nx   (ext_nx)
    );

    fdiv_wave_gen #(.CNT_W(CNT_W), .NUDGE_W(NUDGE_W)) u_wave (
        .clk_in    (clk_in),
        .rst_n     (rst_n),
        .ctl_kill  (ctl_kill),
        .load      (load),
        .running   (running),
        .ctl_nudge (ctl_nudge),
        .p_nx      (p_nx),
        .h_nx      (h_nx),
        .ext_nx    (ext_nx),
        .at_end    (at_end),
        .clk_out   (clk_out)
    );

    // R12: the status rises together with the first output pulse.
    a_r12_enabled_with_edge: assert property (@(posedge clk_in) disable iff (!rst_n)
        $rose(enabled) |-> clk_out);

    // R10: nothing toggles while kill is held.
    a_r10_killed_quiet: assert property (@(posedge clk_in) disable iff (!rst_n)
        ctl_kill |-> (!enabled && !clk_out));

    // R10: input rule, kill is released only with enable already low.
    a_r10_release_after_disable: assert property (@(posedge clk_in) disable iff (!rst_n)
        $fell(ctl_kill) |-> !ctl_enable);

    // R9: the generator stops only while the output is low.
    a_r9_stop_low: assert property (@(posedge clk_in) disable iff (!rst_n)
        $fell(enabled) |-> !clk_out);

endmodule

// File: tb/sim_frac_clk_div.sv
module sim_frac_clk_div;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_enable = 1'b0;
    logic        ctl_kill = 1'b0;
    logic        ctl_dc50 = 1'b0;
    logic [1:0]  ctl_phase = 2'd0;
    logic        ctl_nudge = 1'b0;
    logic [15:0] div_int = 16'd4;
    logic [15:0] div_frac = 16'd0;
    logic        clk_out;
    logic        enabled;

    int   n_chk = 0;
    int   n_fail = 0;
    logic prev_v = 1'b0;
    logic last_v = 1'b0;

    always #5 clk = ~clk;

    frac_clk_div u0 (
        .clk_in(clk), .rst_n(rst_n), .ctl_enable(ctl_enable), .ctl_kill(ctl_kill),
        .ctl_dc50(ctl_dc50), .ctl_phase(ctl_phase), .ctl_nudge(ctl_nudge),
        .div_int(div_int), .div_frac(div_frac), .clk_out(clk_out), .enabled(enabled)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Sample the output 2 ns after every clock edge.
    task automatic half_step();
        prev_v = last_v;
        @(clk);
        #2;
        last_v = clk_out;
    endtask

    task automatic wait_rise();
        last_v = clk_out;
        do half_step(); while (!(!prev_v && last_v));
    endtask

    // From a rise sample to the next rise: cycles and high half-cycles.
    task automatic span(output int cyc, output int hi);
        int halves = 1;
        hi = 1;
        forever begin
            half_step();
            if (!prev_v && last_v) break;
            halves++;
            if (last_v) hi++;
        end
        cyc = halves / 2;
    endtask

    task automatic hard_stop();
        @(negedge clk);
        ctl_kill = 1'b1;
        ctl_enable = 1'b0;
        @(negedge clk);
        ctl_kill = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic start_gen(input int iv, input int fv, input bit dc, input int ph);
        @(negedge clk);
        div_int = 16'(iv);
        div_frac = 16'(fv);
        ctl_dc50 = dc;
        ctl_phase = 2'(ph);
        ctl_enable = 1'b1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R12", "clk_out in reset", int'(clk_out), 0);
        check("R12", "enabled in reset", int'(enabled), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_integer();
        int c, h;
        hard_stop(); start_gen(4, 0, 0, 0); wait_rise(); span(c, h);
        check("R1", "period N=4", c, 4);
        check("R1", "high halves N=4", h, 4);
        hard_stop(); start_gen(5, 0, 0, 0); wait_rise(); span(c, h);
        check("R1", "period N=5", c, 5);
        check("R1", "high halves N=5", h, 4);
    endtask

    task automatic t_dc50();
        int c, h;
        hard_stop(); start_gen(5, 0, 1, 0); wait_rise(); span(c, h);
        check("R5", "period N=5 corrected", c, 5);
        check("R5", "high halves N=5 corrected", h, 5);
        hard_stop(); start_gen(6, 0, 1, 0); wait_rise(); span(c, h);
        check("R5", "high halves N=6 corrected", h, 6);
    endtask

    task automatic t_int_one();
        int c, h;
        hard_stop(); start_gen(1, 0, 0, 0); wait_rise(); span(c, h);
        check("R3", "period N=1", c, 2);
        check("R3", "high halves N=1", h, 2);
    endtask

    task automatic t_int_zero();
        int h = 1;
        hard_stop(); start_gen(0, 0, 0, 0); wait_rise();
        forever begin
            half_step();
            if (!last_v) break;
            h++;
        end
        check("R2", "high halves N=0", h, 65536);
    endtask

    task automatic t_frac();
        int c0, c1, c2, c3, h;
        hard_stop(); start_gen(3, 16'h8000, 0, 0); wait_rise();
        span(c0, h); span(c1, h); span(c2, h); span(c3, h);
        check("R4", "half fraction first period", c0, 3);
        check("R4", "half fraction second period", c1, 4);
        check("R4", "half fraction four periods", c0 + c1 + c2 + c3, 14);
        hard_stop(); start_gen(3, 16'h4000, 0, 0); wait_rise();
        span(c0, h); span(c1, h); span(c2, h); span(c3, h);
        check("R4", "quarter fraction four periods", c0 + c1 + c2 + c3, 13);
        check("R4", "quarter fraction carry period", c3, 4);
    endtask

    // Count rising edges from enable to the first output rise.
    task automatic latency(input int ph, output int k, output int en_before, output int en_at);
        k = 0;
        en_before = 0;
        @(negedge clk);
        ctl_phase = 2'(ph);
        ctl_enable = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(posedge clk);
            #2;
            k++;
            if (clk_out) break;
            en_before = int'(enabled);
        end
        en_at = int'(enabled);
    endtask

    task automatic t_phase();
        int k, eb, ea, c, h;
        hard_stop();
        div_int = 16'd4; div_frac = 16'd0; ctl_dc50 = 1'b0;
        latency(0, k, eb, ea);
        check("R7", "latency phase 0", k, 3);
        check("R12", "enabled before first rise", eb, 0);
        check("R12", "enabled at first rise", ea, 1);
        last_v = clk_out;
        ctl_phase = 2'd3;
        wait_rise(); span(c, h);
        check("R8", "period after phase write while running", c, 4);
        @(negedge clk);
        ctl_enable = 1'b0;
        repeat (20) @(negedge clk);
        latency(3, k, eb, ea);
        check("R7", "latency phase 3", k, 6);
        check("R8", "enabled at delayed rise", ea, 1);
    endtask

    task automatic t_stop();
        int hi = 1;
        int en14 = 0;
        int en16 = 1;
        hard_stop(); start_gen(8, 0, 0, 0); wait_rise();
        for (int i = 1; i <= 40; i++) begin
            half_step();
            if (i == 1) ctl_enable = 1'b0;
            if (last_v) hi++;
            if (i == 14) en14 = int'(enabled);
            if (i == 16) en16 = int'(enabled);
        end
        check("R9", "high halves after stop request", hi, 8);
        check("R9", "enabled in last cycle of period", en14, 1);
        check("R9", "enabled after period end", en16, 0);
    endtask

    task automatic t_kill();
        int hi = 0;
        hard_stop(); start_gen(10, 0, 0, 0); wait_rise();
        #1;
        ctl_kill = 1'b1;
        #1;
        check("R10", "clk_out right after kill", int'(clk_out), 0);
        check("R10", "enabled right after kill", int'(enabled), 0);
        @(negedge clk);
        ctl_enable = 1'b0;
        @(negedge clk);
        ctl_kill = 1'b0;
        for (int i = 0; i < 30; i++) begin
            half_step();
            if (last_v) hi++;
        end
        check("R10", "high samples after kill release", hi, 0);
        check("R10", "enabled after kill release", int'(enabled), 0);
    endtask

    task automatic t_nudge();
        int c, h;
        hard_stop();
        @(negedge clk);
        ctl_nudge = ~ctl_nudge;
        repeat (3) @(negedge clk);
        start_gen(6, 0, 0, 0); wait_rise(); span(c, h);
        check("R11", "period after idle nudge", c, 6);
        ctl_nudge = ~ctl_nudge;
        span(c, h);
        check("R11", "period after one nudge edge", c, 7);
        ctl_nudge = ~ctl_nudge;
        span(c, h);
        check("R11", "period after opposite nudge edge", c, 7);
        span(c, h);
        check("R11", "period after nudge consumed", c, 6);
        check("R11", "high halves unchanged by nudge", h, 6);
    endtask

    task automatic t_onfly();
        int c, h;
        hard_stop(); start_gen(4, 0, 0, 0); wait_rise();
        div_int = 16'd7;
        span(c, h);
        check("R6", "period in progress at divisor change", c, 4);
        check("R6", "high halves in progress at divisor change", h, 4);
        ctl_dc50 = 1'b1;
        span(c, h);
        check("R6", "first period with new divisor", c, 7);
        check("R6", "high halves before duty change applies", h, 6);
        span(c, h);
        check("R6", "high halves after duty change applies", h, 7);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_integer();
        t_dc50();
        t_int_one();
        t_frac();
        t_phase();
        t_stop();
        t_kill();
        t_nudge();
        t_onfly();
        t_int_zero();
        hard_stop();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule